// File: doc/BRIEF.md
# Character Display Address Counter Unit

This unit holds the address pointer and the horizontal scroll state of a character display controller. It takes one instruction or data byte per accepted transfer. Instructions move the pointer, reload it, choose which RAM it points into, scroll the visible window, change the line format and switch the display, cursor and blink enables. A data byte is turned into a one-cycle RAM write strobe at the current pointer, and the pointer then steps to the next position.

In two-line format the display memory is used as two separate 40-entry windows, so the pointer steps across the gap between them. In one-line format it uses one 80-entry range. A screen scroll changes only a window offset and never the pointer. A clear instruction sweeps all 80 character positions with the blank code while the unit reports busy. Any transfer offered while busy is dropped.

Top module: `charlcd_acu`

## Requirements
- R1: After reset, the pointer is 00h in display RAM (target code 0), the offset is 0, the display, cursor and blink enables are 0, busy is 0, no write strobe is active, and the step direction is increment.
- R2: An accepted data byte gives wr_en high for one cycle, in the cycle after acceptance. The strobe carries the pointer value from before the transfer, the current target and the byte. The pointer then steps by +1 when the entry direction bit is 1 and by -1 when it is 0.
- R3: Instruction 01h sets the pointer to 00h in display RAM, the offset to 0 and the direction to increment. It then issues 80 writes of 20h, one per cycle: positions 0 to 39 go to 00h to 27h and positions 40 to 79 to 40h to 67h in two-line format, and to 00h to 4Fh in one-line format. Busy stays high for 80 + BUSY_CYC cycles.
- R4: Instruction 0000001x sets the pointer to 00h in display RAM and the offset to 0, and issues no write.
- R5: Two-line display RAM stepping goes 27h to 40h and 67h to 00h upward, and 40h to 27h and 00h to 67h downward.
- R6: One-line stepping wraps between 4Fh and 00h in both directions. With the double-height bit set in one-line format, the range is 00h to 27h and it wraps the same way.
- R7: Instruction 000001 D S sets direction D and auto-scroll S. With S = 1, a display RAM data write adds 1 to the offset when D = 1 and subtracts 1 when D = 0, modulo the line length: 40 in two-line or double-height format, 80 otherwise. Writes to character-pattern RAM or icon RAM never change the offset.
- R8: Instruction 0001 C R xx with the extended set off works as follows. C = 1 scrolls the screen: R = 1 subtracts 1 from the offset, R = 0 adds 1, and the pointer does not change. C = 0 steps the pointer: R = 1 gives +1, R = 0 gives -1.
- R9: Instruction 00001 D C B loads the display, cursor and blink enables from those bits.
- R10: Instruction 001 x N H x E loads two-line format (N), double height (H) and the extended set (E), and clears the offset to 0.
- R11: 1aaaaaaa loads the pointer with a in display RAM. With E = 0, 01aaaaaa loads a in character-pattern RAM (target code 1). With E = 1, 0100aaaa loads a in icon RAM (target code 2), and 0001xxxx and 0101xxxx to 0111xxxx change neither the pointer nor the offset. Character-pattern addresses wrap within 6 bits and icon addresses wrap within 4 bits.
- R12: Each accepted transfer other than 01h holds busy high for BUSY_CYC cycles, starting the cycle after acceptance. Any transfer offered while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | A transfer is offered this cycle |
| is_data | input | 1 | 1: RAM data byte, 0: instruction |
| instr_byte | input | 8 | Instruction code or data byte |
| ac_addr | output | 7 | Current pointer |
| ac_target | output | 2 | RAM the pointer selects: 0 display, 1 pattern, 2 icon |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 7 | Write address |
| wr_target | output | 2 | RAM the write goes to |
| wr_data | output | 8 | Write data |
| shift_ofs | output | 7 | Display window offset |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| busy | output | 1 | Unit is busy; transfers are ignored |

## Verification
The pointer, target, offset, enables and busy all come from registers loaded at the accepting edge. The bench drives each transfer on a falling edge, lets one rising edge accept it, and reads the results on the next falling edge. The strobe for a data byte is due on that same falling edge. For a clear, the first blank write appears one cycle later and the rest follow on consecutive cycles. Busy lengths are measured by counting falling edges from the first sample until busy drops. Ignored transfers are offered during that window and checked through the pointer once busy has dropped.

// File: rtl/charlcd_acu_pkg.sv
`timescale 1ns/1ps
package charlcd_acu_pkg;
    typedef enum logic [1:0] {
        TGT_DD   = 2'd0,
        TGT_CG   = 2'd1,
        TGT_ICON = 2'd2
    } tgt_e;

    localparam logic [6:0] LINE1_LAST  = 7'h27;
    localparam logic [6:0] LINE2_FIRST = 7'h40;
    localparam logic [6:0] LINE2_LAST  = 7'h67;
    localparam logic [6:0] FLAT_LAST   = 7'h4F;
    localparam logic [7:0] BLANK_CODE  = 8'h20;
endpackage

// File: rtl/charlcd_acu_addr_step.sv
`timescale 1ns/1ps
module charlcd_acu_addr_step
    import charlcd_acu_pkg::*;
(
    input  logic [6:0] cur,
    input  logic       up,
    input  tgt_e       tgt,
    input  logic       two_line,
    input  logic       dbl,
    output logic [6:0] nxt
);
    logic [6:0] top;

    always_comb begin
        top = dbl ? LINE1_LAST : FLAT_LAST;
        nxt = cur;
        case (tgt)
            TGT_CG:   nxt = {1'b0, (up ? cur[5:0] + 6'd1 : cur[5:0] - 6'd1)};
            TGT_ICON: nxt = {3'b000, (up ? cur[3:0] + 4'd1 : cur[3:0] - 4'd1)};
            default: begin
                if (two_line) begin
                    if (up)
                        nxt = (cur == LINE1_LAST) ? LINE2_FIRST :
                              (cur == LINE2_LAST) ? 7'h00 : cur + 7'd1;
                    else
                        nxt = (cur == LINE2_FIRST) ? LINE1_LAST :
                              (cur == 7'h00) ? LINE2_LAST : cur - 7'd1;
                end else begin
                    if (up)
                        nxt = (cur >= top) ? 7'h00 : cur + 7'd1;
                    else
                        nxt = (cur == 7'h00) ? top : cur - 7'd1;
                end
            end
        endcase
    end
endmodule

// File: rtl/charlcd_acu_shift_step.sv
`timescale 1ns/1ps
module charlcd_acu_shift_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] ofs,
    input  logic         left,
    input  logic [W-1:0] modlen,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (left)
            nxt = (ofs >= modlen - W'(1)) ? '0 : ofs + W'(1);
        else
            nxt = (ofs == '0) ? modlen - W'(1) : ofs - W'(1);
    end
endmodule

// File: rtl/charlcd_acu_busy_timer.sv
`timescale 1ns/1ps
module charlcd_acu_busy_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/charlcd_acu.sv
`timescale 1ns/1ps
module charlcd_acu
    import charlcd_acu_pkg::*;
#(
    parameter int BUSY_CYC  = 4,
    parameter int POSITIONS = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_valid,
    input  logic       is_data,
    input  logic [7:0] instr_byte,
    output logic [6:0] ac_addr,
    output logic [1:0] ac_target,
    output logic       wr_en,
    output logic [6:0] wr_addr,
    output logic [1:0] wr_target,
    output logic [7:0] wr_data,
    output logic [6:0] shift_ofs,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       busy
);
    localparam int CLR_CYC  = POSITIONS + BUSY_CYC;
    localparam int CW       = $clog2(CLR_CYC + 1);
    localparam int LINE_LEN = POSITIONS / 2;
    localparam logic [6:0] GAP = LINE2_FIRST - 7'(LINE_LEN);

    typedef struct packed {
        logic [6:0] ac;
        tgt_e       tgt;
        logic       id;
        logic       s;
        logic       disp;
        logic       cur;
        logic       blk;
        logic       n;
        logic       dh;
        logic       ext;
        logic [6:0] ofs;
        logic       wr_en;
        logic [6:0] wr_addr;
        tgt_e       wr_tgt;
        logic [7:0] wr_data;
        logic       clr;
        logic [6:0] clr_idx;
    } st_t;

    localparam st_t ST_RST = '{ac: 7'h00, tgt: TGT_DD, id: 1'b1, s: 1'b0,
                               disp: 1'b0, cur: 1'b0, blk: 1'b0, n: 1'b0,
                               dh: 1'b0, ext: 1'b0, ofs: 7'h00, wr_en: 1'b0,
                               wr_addr: 7'h00, wr_tgt: TGT_DD, wr_data: 8'h00,
                               clr: 1'b0, clr_idx: 7'h00};

    st_t st_d, st_q;
    logic          accept, step_up, shift_left, tmr_load;
    logic [CW-1:0] tmr_val;
    logic [6:0]    step_nxt, shift_nxt, modlen;

    assign accept     = instr_valid && !busy;
    assign step_up    = is_data ? st_q.id : instr_byte[2];
    assign shift_left = is_data ? st_q.id : !instr_byte[2];
    assign modlen     = (st_q.n || st_q.dh) ? 7'(LINE_LEN) : 7'(POSITIONS);

    charlcd_acu_addr_step u_step (
        .cur(st_q.ac), .up(step_up), .tgt(st_q.tgt),
        .two_line(st_q.n), .dbl(st_q.dh), .nxt(step_nxt)
    );

    charlcd_acu_shift_step #(.W(7)) u_shift (
        .ofs(st_q.ofs), .left(shift_left), .modlen(modlen), .nxt(shift_nxt)
    );

    charlcd_acu_busy_timer #(.W(CW)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(busy)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = CW'(BUSY_CYC);
        if (st_q.clr) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_tgt  = TGT_DD;
            st_d.wr_data = BLANK_CODE;
            st_d.wr_addr = (st_q.n && st_q.clr_idx >= 7'(LINE_LEN)) ?
                           st_q.clr_idx + GAP : st_q.clr_idx;
            st_d.clr_idx = st_q.clr_idx + 7'd1;
            if (st_q.clr_idx == 7'(POSITIONS - 1))
                st_d.clr = 1'b0;
        end
        if (accept) begin
            tmr_load = 1'b1;
            if (is_data) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_addr = st_q.ac;
                st_d.wr_tgt  = st_q.tgt;
                st_d.wr_data = instr_byte;
                st_d.ac      = step_nxt;
                if (st_q.s && st_q.tgt == TGT_DD)
                    st_d.ofs = shift_nxt;
            end else begin
                casez (instr_byte)
                    8'b1???????: begin
                        st_d.ac  = instr_byte[6:0];
                        st_d.tgt = TGT_DD;
                    end
                    8'b01??????: begin
                        if (!st_q.ext) begin
                            st_d.ac  = {1'b0, instr_byte[5:0]};
                            st_d.tgt = TGT_CG;
                        end else if (instr_byte[5:4] == 2'b00) begin
                            st_d.ac  = {3'b000, instr_byte[3:0]};
                            st_d.tgt = TGT_ICON;
                        end
                    end
                    8'b001?????: begin
                        st_d.n   = instr_byte[3];
                        st_d.dh  = instr_byte[2];
                        st_d.ext = instr_byte[0];
                        st_d.ofs = 7'h00;
                    end
                    8'b0001????: begin
                        if (!st_q.ext) begin
                            if (instr_byte[3]) st_d.ofs = shift_nxt;
                            else               st_d.ac  = step_nxt;
                        end
                    end
                    8'b00001???: begin
                        st_d.disp = instr_byte[2];
                        st_d.cur  = instr_byte[1];
                        st_d.blk  = instr_byte[0];
                    end
                    8'b000001??: begin
                        st_d.id = instr_byte[1];
                        st_d.s  = instr_byte[0];
                    end
                    8'b0000001?: begin
                        st_d.ac  = 7'h00;
                        st_d.tgt = TGT_DD;
                        st_d.ofs = 7'h00;
                    end
                    8'b00000001: begin
                        st_d.ac      = 7'h00;
                        st_d.tgt     = TGT_DD;
                        st_d.ofs     = 7'h00;
                        st_d.id      = 1'b1;
                        st_d.clr     = 1'b1;
                        st_d.clr_idx = 7'h00;
                        tmr_val      = CW'(CLR_CYC);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign ac_addr   = st_q.ac;
    assign ac_target = st_q.tgt;
    assign wr_en     = st_q.wr_en;
    assign wr_addr   = st_q.wr_addr;
    assign wr_target = st_q.wr_tgt;
    assign wr_data   = st_q.wr_data;
    assign shift_ofs = st_q.ofs;
    assign disp_on   = st_q.disp;
    assign cursor_on = st_q.cur;
    assign blink_on  = st_q.blk;
endmodule

// File: rtl/charlcd_acu_checker.sv
`timescale 1ns/1ps
module charlcd_acu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic       is_data,
    input logic [7:0] instr_byte,
    input logic [6:0] ac_addr,
    input logic       wr_en,
    input logic [6:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [6:0] shift_ofs,
    input logic       busy,
    input logic       ext_mode
);
    logic acc;
    assign acc = instr_valid && !busy;

    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && is_data |=> wr_en && wr_data == $past(instr_byte) && wr_addr == $past(ac_addr));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !is_data && instr_byte == 8'h01 |=> ac_addr == 7'h00 && shift_ofs == 7'h00 && busy);

    p_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !is_data && instr_byte[7:1] == 7'b0000001 |=> ac_addr == 7'h00 && shift_ofs == 7'h00);

    p_screen_keeps_ac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !is_data && !ext_mode && instr_byte[7:3] == 5'b00011 |=> $stable(ac_addr));

    p_fset_clears_ofs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !is_data && instr_byte[7:5] == 3'b001 |=> shift_ofs == 7'h00);

    p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    p_ignored_when_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ac_addr));
endmodule

bind charlcd_acu charlcd_acu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_data(is_data),
    .instr_byte(instr_byte), .ac_addr(ac_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shift_ofs(shift_ofs), .busy(busy), .ext_mode(st_q.ext)
);

// File: tb/charlcd_acu_bench.sv
`timescale 1ns/1ps
module charlcd_acu_bench;
    localparam int B = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       is_data = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic [6:0] ac_addr, wr_addr, shift_ofs;
    logic [1:0] ac_target, wr_target;
    logic [7:0] wr_data;
    logic       wr_en, disp_on, cursor_on, blink_on, busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    charlcd_acu #(.BUSY_CYC(B), .POSITIONS(80)) u_charlcd_acu (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_data(is_data),
        .instr_byte(instr_byte), .ac_addr(ac_addr), .ac_target(ac_target),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_target(wr_target), .wr_data(wr_data),
        .shift_ofs(shift_ofs), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic rs, input logic [7:0] b);
        @(negedge clk);
        while (busy) @(negedge clk);
        is_data = rs; instr_byte = b; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 ac", ac_addr, 0);
        chk("R1 target", ac_target, 0);
        chk("R1 ofs", shift_ofs, 0);
        chk("R1 enables", {disp_on, cursor_on, blink_on}, 0);
        chk("R1 busy", busy, 0);
        chk("R1 wr_en", wr_en, 0);
    endtask

    task automatic t_display_ctrl;
        send(0, 8'h0F);
        chk("R9 all on", {disp_on, cursor_on, blink_on}, 3'b111);
        send(0, 8'h0C);
        chk("R9 disp only", {disp_on, cursor_on, blink_on}, 3'b100);
    endtask

    task automatic t_write_inc;
        int n;
        send(1, 8'h41);
        chk("R2 wr_en", wr_en, 1);
        chk("R2 wr_addr", wr_addr, 0);
        chk("R2 wr_data", wr_data, 8'h41);
        chk("R2 ac step", ac_addr, 1);
        count_busy(n);
        chk("R12 busy length", n, B);
        chk("R2 strobe single", wr_en, 0);
    endtask

    task automatic t_two_line_wrap;
        send(0, 8'h38); send(0, 8'h06);
        send(0, 8'hA7); send(1, 8'h11);
        chk("R5 27->40", ac_addr, 7'h40);
        send(0, 8'hE7); send(1, 8'h11);
        chk("R5 67->00", ac_addr, 7'h00);
        send(0, 8'h04);
        send(0, 8'hC0); send(1, 8'h11);
        chk("R5 40->27", ac_addr, 7'h27);
        send(0, 8'h80); send(1, 8'h11);
        chk("R5 00->67", ac_addr, 7'h67);
    endtask

    task automatic t_one_line_wrap;
        send(0, 8'h30); send(0, 8'h06);
        send(0, 8'hCF); send(1, 8'h22);
        chk("R6 4F->00", ac_addr, 7'h00);
        send(0, 8'h04); send(1, 8'h22);
        chk("R6 00->4F", ac_addr, 7'h4F);
        send(0, 8'h34); send(0, 8'h06);
        send(0, 8'hA7); send(1, 8'h22);
        chk("R6 dbl 27->00", ac_addr, 7'h00);
        send(0, 8'h04); send(1, 8'h22);
        chk("R6 dbl 00->27", ac_addr, 7'h27);
    endtask

    task automatic t_entry_shift;
        send(0, 8'h38); send(0, 8'h80); send(0, 8'h07);
        send(1, 8'h33);
        chk("R7 left shift", shift_ofs, 1);
        send(0, 8'h05); send(1, 8'h33);
        chk("R7 right shift", shift_ofs, 0);
        send(1, 8'h33);
        chk("R7 right wrap", shift_ofs, 39);
        send(0, 8'h40); send(1, 8'h33);
        chk("R7 pattern write no shift", shift_ofs, 39);
        chk("R11 pattern wrap 00->3F", ac_addr, 7'h3F);
        chk("R11 pattern target", ac_target, 1);
    endtask

    task automatic t_shift_instr;
        send(0, 8'h38); send(0, 8'h80);
        send(0, 8'h1C);
        chk("R8 screen right ofs", shift_ofs, 39);
        chk("R8 screen right ac", ac_addr, 0);
        send(0, 8'h18);
        chk("R8 screen left ofs", shift_ofs, 0);
        send(0, 8'h18);
        send(0, 8'h14);
        chk("R8 cursor right", ac_addr, 1);
        send(0, 8'h10); send(0, 8'h10);
        chk("R8 cursor left wrap", ac_addr, 7'h67);
        chk("R8 cursor keeps ofs", shift_ofs, 1);
        send(0, 8'h38);
        chk("R10 fset clears ofs", shift_ofs, 0);
    endtask

    task automatic t_set_addr;
        send(0, 8'h45);
        chk("R11 pattern addr", ac_addr, 5);
        chk("R11 pattern tgt", ac_target, 1);
        send(0, 8'h39);
        send(0, 8'h4F);
        chk("R11 icon addr", ac_addr, 7'h0F);
        chk("R11 icon tgt", ac_target, 2);
        send(0, 8'h1C);
        chk("R11 ext 0001 ignored ofs", shift_ofs, 0);
        chk("R11 ext 0001 ignored ac", ac_addr, 7'h0F);
        send(0, 8'h55);
        chk("R11 ext 0101 ignored", {ac_target, ac_addr}, {2'd2, 7'h0F});
        send(0, 8'h06); send(1, 8'h01);
        chk("R11 icon wrap", ac_addr, 0);
        chk("R11 icon write target", wr_target, 2);
        send(0, 8'h38);
    endtask

    task automatic t_home;
        send(0, 8'h38); send(0, 8'hC5); send(0, 8'h18); send(0, 8'h18);
        send(0, 8'h02);
        chk("R4 ac", ac_addr, 0);
        chk("R4 ofs", shift_ofs, 0);
        chk("R4 tgt", ac_target, 0);
        chk("R4 no write", wr_en, 0);
    endtask

    task automatic t_clear;
        int nb = 0;
        int nw = 0;
        int bad = 0;
        send(0, 8'h38); send(0, 8'h04); send(0, 8'hC3); send(0, 8'h18);
        send(0, 8'h01);
        chk("R3 ac", ac_addr, 0);
        chk("R3 ofs", shift_ofs, 0);
        for (int i = 0; i < 120; i++) begin
            if (busy) nb++;
            if (wr_en) begin
                int exp_a;
                exp_a = (nw < 40) ? nw : nw + 24;
                if (wr_addr != 7'(exp_a) || wr_data != 8'h20 || wr_target != 2'd0) bad++;
                nw++;
            end
            @(negedge clk);
        end
        chk("R3 write count", nw, 80);
        chk("R3 write sequence", bad, 0);
        chk("R3 busy length", nb, 80 + B);
        send(1, 8'h41);
        chk("R3 direction forced up", ac_addr, 1);
    endtask

    task automatic t_busy_ignore;
        send(0, 8'h90);
        is_data = 1'b0; instr_byte = 8'h85; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R12 ignored while busy", ac_addr, 7'h10);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_display_ctrl();
        t_write_inc();
        t_two_line_wrap();
        t_one_line_wrap();
        t_entry_shift();
        t_shift_instr();
        t_set_addr();
        t_home();
        t_clear();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule